// File: doc/BRIEF.md
# Jittered UART Bit Timer

This block produces the timing strobes for one direction of a serial asynchronous frame. A divisor sets the oversample period to `divisor + 1` clock cycles. A nominal bit slot lasts sixteen oversample ticks. Each slot of the frame carries its own 2-bit adjust code. The code can leave the slot at nominal width, add one oversample tick, or remove one. A frame whose rate is not an exact multiple of the clock can then be trimmed slot by slot, so the error that builds up over the frame stays small. No fractional divider is needed for this.

A frame begins on a one-cycle `frame_start` pulse. It runs for the number of slots given on `frame_len`, then stops by itself. During the frame the block emits three strobes: an oversample tick, a strobe on the last tick of every slot, and a mid-slot sample strobe for a receiver. The current slot number is also output, so a shifter can use it. A transmitter and a receiver each use their own instance, with their own adjust words and a shared divisor.

Top module: `bit_jitter_timer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `active` is low, `slot_idx` is 0, and `os_tick`, `bit_end` and `sample_stb` all stay low.
- R2: While a frame is in progress, `os_tick` pulses for one cycle every `divisor + 1` cycles. The first pulse comes in the cycle `divisor` cycles after the cycle in which `frame_start` is sampled.
- R3: A slot whose adjust code is 0 lasts 16 ticks. `bit_end` coincides with its 16th tick and `sample_stb` with its 8th tick.
- R4: A slot whose adjust code is 1 lasts 17 ticks. `bit_end` coincides with its 17th tick and `sample_stb` with its 8th tick.
- R5: A slot whose adjust code is 3 lasts 15 ticks. `bit_end` coincides with its 15th tick and `sample_stb` with its 7th tick.
- R6: Adjust code 2 times a slot exactly as code 0 does.
- R7: The code for slot n is `adjust[2n+1:2n]`. `slot_idx` starts at 0 and steps by one on the cycle after each `bit_end`. `bit_end` and `sample_stb` are only ever issued together with `os_tick`.
- R8: After the `bit_end` of slot `frame_len - 1`, `active` falls on the next cycle and no further strobes occur. Codes for slots beyond the frame length have no effect.
- R9: A `frame_start` pulse during a frame abandons that frame. Timing restarts from slot 0 with a fresh oversample count, and no strobe is issued in the cycle of the pulse.
- R10: A `frame_len` of 0 runs one slot. A value above 12 runs 12 slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that begins (or restarts) a frame |
| divisor | input | 16 | Oversample period minus one, in clock cycles |
| adjust | input | 24 | 2-bit adjust code per slot, slot n at bits 2n+1:2n |
| frame_len | input | 4 | Number of slots in the frame (clamped to 1..12) |
| os_tick | output | 1 | Oversample tick |
| bit_end | output | 1 | Last tick of the current slot |
| sample_stb | output | 1 | Mid-slot sample point |
| slot_idx | output | 4 | Index of the slot being timed |
| active | output | 1 | Frame in progress |

## Verification
The hardest situation to reach is a restart that lands partway through a slot. Such a restart must throw away both the partly counted oversample period and the partly counted slot, and a stale strobe must not leak out. The bench starts a long frame and lets part of it run. It then pulses `frame_start` again with a different adjust pattern, and checks that every later strobe falls exactly where the new frame predicts it. It also uses adjust patterns that mix all four codes in one frame, and frame lengths outside the valid range, so that the odd tick counts and the clamping are both exercised.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   typedef enum logic [1:0] {
      ADJ_NOMINAL = 2'd0,
      ADJ_WIDEN   = 2'd1,
      ADJ_INERT   = 2'd2,
      ADJ_NARROW  = 2'd3
   } adj_code_e;

   // Slot length in oversample ticks for a given code and nominal ratio.
   function automatic int unsigned slot_ticks(input adj_code_e code, input int unsigned osr);
      case (code)
         ADJ_WIDEN:  return osr + 1;
         ADJ_NARROW: return osr - 1;
         default:    return osr;
      endcase
   endfunction

endpackage

// File: rtl/ubt_prescale.sv
module ubt_prescale #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && !start && (cnt == divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start || !run)
         cnt <= '0;
      else if (cnt == divisor)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ubt_slot_len.sv
module ubt_slot_len
   import ubt_pkg::*;
#(
   parameter int MAX_SLOTS = 12,
   parameter int OSR       = 16,
   parameter int SLOT_W    = 4,
   parameter int TW        = 5
) (
   input  logic [2*MAX_SLOTS-1:0] adjust,
   input  logic [SLOT_W-1:0]      slot,
   output logic [TW-1:0]          len,
   output logic [TW-1:0]          mid
);
   logic [TW-1:0] lens [MAX_SLOTS];

   for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_slot
      always_comb lens[i] = TW'(slot_ticks(adj_code_e'(adjust[2*i +: 2]), OSR));
   end

   always_comb begin
      len = TW'(OSR);
      for (int i = 0; i < MAX_SLOTS; i++)
         if (slot == SLOT_W'(i)) len = lens[i];
      mid = len >> 1;
   end
endmodule

// File: rtl/ubt_slot_seq.sv
module ubt_slot_seq #(
   parameter int MAX_SLOTS = 12,
   parameter int SLOT_W    = 4,
   parameter int TW        = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic [SLOT_W-1:0] frame_len,
   input  logic [TW-1:0]     len,
   input  logic [TW-1:0]     mid,
   output logic              bit_end,
   output logic              sample,
   output logic [SLOT_W-1:0] slot,
   output logic              active
);
   logic [TW-1:0]     tcnt;
   logic [SLOT_W-1:0] eff_len;
   logic              last;

   always_comb begin
      if (frame_len == '0)
         eff_len = SLOT_W'(1);
      else if (frame_len > SLOT_W'(MAX_SLOTS))
         eff_len = SLOT_W'(MAX_SLOTS);
      else
         eff_len = frame_len;
   end

   assign last    = (slot == eff_len - 1'b1);
   assign bit_end = tick && (tcnt == len - 1'b1);
   assign sample  = tick && (tcnt == mid - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         slot   <= '0;
         tcnt   <= '0;
      end else if (start) begin
         active <= 1'b1;
         slot   <= '0;
         tcnt   <= '0;
      end else if (tick) begin
         if (tcnt == len - 1'b1) begin
            tcnt <= '0;
            if (last) begin
               active <= 1'b0;
               slot   <= '0;
            end else begin
               slot <= slot + 1'b1;
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bit_jitter_timer.sv
module bit_jitter_timer #(
   parameter int DIV_W     = 16,
   parameter int MAX_SLOTS = 12,
   parameter int OSR       = 16,
   parameter int SLOT_W    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_start,
   input  logic [DIV_W-1:0]       divisor,
   input  logic [2*MAX_SLOTS-1:0] adjust,
   input  logic [SLOT_W-1:0]      frame_len,
   output logic                   os_tick,
   output logic                   bit_end,
   output logic                   sample_stb,
   output logic [SLOT_W-1:0]      slot_idx,
   output logic                   active
);
   localparam int TW = $clog2(OSR + 2);

   if (OSR < 4) begin : g_bad_osr
      $error("OSR must be at least 4");
   end
   if (MAX_SLOTS < 1 || MAX_SLOTS > (2**SLOT_W) - 1) begin : g_bad_slots
      $error("MAX_SLOTS does not fit SLOT_W");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be positive");
   end

   logic [TW-1:0] cur_len, cur_mid;

   ubt_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (frame_start),
      .run     (active),
      .divisor (divisor),
      .tick    (os_tick)
   );

   ubt_slot_len #(.MAX_SLOTS(MAX_SLOTS), .OSR(OSR), .SLOT_W(SLOT_W), .TW(TW)) u_len (
      .adjust (adjust),
      .slot   (slot_idx),
      .len    (cur_len),
      .mid    (cur_mid)
   );

   ubt_slot_seq #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W), .TW(TW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (frame_start),
      .tick      (os_tick),
      .frame_len (frame_len),
      .len       (cur_len),
      .mid       (cur_mid),
      .bit_end   (bit_end),
      .sample    (sample_stb),
      .slot      (slot_idx),
      .active    (active)
   );
endmodule

// File: rtl/ubt_chk.sv
module ubt_chk #(
   parameter int MAX_SLOTS = 12,
   parameter int SLOT_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic [SLOT_W-1:0] frame_len,
   input logic              os_tick,
   input logic              bit_end,
   input logic              sample_stb,
   input logic [SLOT_W-1:0] slot_idx,
   input logic              active
);
   logic [SLOT_W-1:0] lim;
   always_comb begin
      if (frame_len == '0) lim = SLOT_W'(1);
      else if (frame_len > SLOT_W'(MAX_SLOTS)) lim = SLOT_W'(MAX_SLOTS);
      else lim = frame_len;
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!os_tick && !bit_end && !sample_stb));

   // R7
   end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end || sample_stb) |-> os_tick);

   // R7
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && !frame_start && (slot_idx != lim - 1'b1)) |=>
         (slot_idx == $past(slot_idx) + 1'b1));

   // R8
   frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && !frame_start && (slot_idx == lim - 1'b1)) |=> !active);

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (active && slot_idx == '0));

   // R9
   start_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (!os_tick && !bit_end && !sample_stb));
endmodule

bind bit_jitter_timer ubt_chk #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .frame_len   (frame_len),
   .os_tick     (os_tick),
   .bit_end     (bit_end),
   .sample_stb  (sample_stb),
   .slot_idx    (slot_idx),
   .active      (active)
);

// File: tb/sim_bit_jitter_timer.sv
`timescale 1ns/1ps
module sim_bit_jitter_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic [15:0] divisor = '0;
   logic [23:0] adjust = '0;
   logic [3:0]  frame_len = 4'd10;
   logic        os_tick, bit_end, sample_stb, active;
   logic [3:0]  slot_idx;

   always #10 clk = ~clk;

   bit_jitter_timer u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .divisor(divisor),
      .adjust(adjust), .frame_len(frame_len), .os_tick(os_tick), .bit_end(bit_end),
      .sample_stb(sample_stb), .slot_idx(slot_idx), .active(active)
   );

   typedef struct {
      int cyc;
      bit is_end;
      int slot;
      int ticks;
   } ev_t;

   ev_t exp_q[$];
   int  n_vec = 0;
   int  n_bad = 0;
   bit  done = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic finish_up();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // Driver: launch a frame and push the expected strobe schedule.
   task automatic run_frame(input int d, input logic [23:0] adj, input int fl);
      int eff, t, ln, md, code;
      @(posedge clk); #2;
      divisor = 16'(d); adjust = adj; frame_len = 4'(fl); frame_start = 1'b1;
      @(posedge clk); #2;
      frame_start = 1'b0;
      exp_q.delete();
      eff = (fl == 0) ? 1 : ((fl > 12) ? 12 : fl);
      t = 0;
      for (int s = 0; s < eff; s++) begin
         code = int'(adj[2*s +: 2]);
         ln = (code == 1) ? 17 : ((code == 3) ? 15 : 16);
         md = ln / 2;
         exp_q.push_back('{(t + md) * (d + 1) - 1, 1'b0, s, t + md});
         exp_q.push_back('{(t + ln) * (d + 1) - 1, 1'b1, s, t + ln});
         t += ln;
      end
   endtask

   task automatic wait_idle(input string req);
      while (active) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(exp_q.size() == 0, req, "pending strobes at frame end", exp_q.size(), 0);
      chk(!active && slot_idx == 0, req, "idle state after frame", int'(slot_idx), 0);
   endtask

   // Monitor: compares each strobe against the scoreboard queue.
   int rel = 0;
   int tcount = 0;
   bit pend = 0;
   always @(negedge clk) begin
      ev_t e;
      if (pend) begin rel = 0; tcount = 0; end
      else rel = rel + 1;
      if (os_tick) tcount = tcount + 1;
      if (rst_n && (bit_end || sample_stb)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected strobe at cycle", rel, -1);
         end else begin
            e = exp_q.pop_front();
            // R3 R4 R5 R6: slot lengths and sample points; R2 tick spacing
            chk(e.is_end == bit_end && e.is_end != sample_stb, "R3", "strobe kind", int'(bit_end), int'(e.is_end));
            chk(rel == e.cyc, "R2", "strobe cycle", rel, e.cyc);
            chk(tcount == e.ticks, "R4", "tick count at strobe", tcount, e.ticks);
            // R7: slot index during strobe
            chk(int'(slot_idx) == e.slot, "R7", "slot index", int'(slot_idx), e.slot);
         end
      end
      pend = frame_start;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk(!active && !os_tick && !bit_end && !sample_stb && slot_idx == 0, "R1", "reset outputs", int'(active), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!active && !os_tick, "R1", "idle after reset", int'(os_tick), 0);

      // R3: all nominal slots
      run_frame(3, 24'h000000, 10);
      wait_idle("R3");

      // R4 R5 R6 R7: mixed codes (1,3,2,0 repeating)
      run_frame(2, {6{8'b00_10_11_01}}, 12);
      wait_idle("R5");

      // R4: all widened, divisor 0
      run_frame(0, 24'h555555, 9);
      wait_idle("R4");

      // R8: codes beyond frame length must not act
      run_frame(1, 24'hFFF000, 6);
      wait_idle("R8");

      // R10: frame_len 0 runs one slot, 15 runs twelve
      run_frame(1, 24'h000003, 0);
      wait_idle("R10");
      run_frame(0, 24'hAAAAAA, 15);
      wait_idle("R10");

      // R9: restart partway through a slot
      run_frame(2, 24'h000000, 12);
      repeat (77) @(negedge clk);
      run_frame(2, 24'h00C1C1, 5);
      wait_idle("R9");

      done = 1;
      finish_up();
   end
endmodule